// File: doc/BRIEF.md
# Converter Host Register and Interrupt Front End

This block is the processor-facing register file for an on-chip converter's command channel. A simple strobe bus reads and writes 32-bit words at byte addresses. The block holds a configuration word, a sticky interrupt status word, an interrupt mask and a channel control word. It composes a live channel status word from the data-queue fill count that a companion command engine reports. It drives one level interrupt line.

Command words written by software are handed to the engine as a one-cycle push strobe. Reads of the result port pop the engine's head entry. Accesses that the map does not allow are dropped without effect and flagged by a one-cycle error pulse. Read data, the error pulse, the push/pop strobes and the interrupt are all registered. Each appears on the clock edge that follows the request.

Top module: `adc_host_regs`

## Requirements
- R1: After reset: the configuration word (byte 0x00) reads 0x00001814, interrupt status (0x04) reads 0x00000200, interrupt mask (0x08) reads 0xFFFFFFFF, channel control (0x18) reads 0x00000010, and `irq` is 0.
- R2: A write to the configuration word stores the value unmodified. Bits 19:16 of that word are the data-queue threshold.
- R3: A write to the interrupt mask keeps bits 9:0 and zeroes bits 31:10.
- R4: Writing interrupt status clears every bit that is set in the written value. Bit 9 (command queue below threshold) is set again in the same update, so it always reads 1.
- R5: Status bit 8 is set in every cycle in which the data-queue count is strictly greater than configuration bits 19:16. Once set, it stays set until it is cleared by a write. A clear and a set falling in the same cycle leave the bit set.
- R6: `irq` is high one edge after any interrupt status bit is 1 while its mask bit is 0, and it is low otherwise.
- R7: A read of channel status (0x0C) returns the following fields:
  - bit 10 is always 1;
  - bits 15:12 hold the data-queue count;
  - bit 8 is 1 when the count is 0;
  - bit 9 is 1 when the count equals DEPTH.
- R8: A write to channel control stores the written value ANDed with 0x00FFFEFF. Bit 4 set means the command channel is held in reset.
- R9: A write to the command port (0x10) raises `cmd_push` for one cycle with the written word on `cmd_data`, but only while channel control bit 4 is 0. Otherwise no push occurs.
- R10: A read of the result port (0x14) returns `rd_head` zero-extended and raises `rd_pop` for one cycle, together with `rsp_valid`.
- R11: The following accesses are illegal: a read of 0x10, a write of 0x0C or 0x14, an address above 0x18, and a misaligned address. An illegal access changes no register, causes no push or pop, returns 0 if it is a read, and pulses `acc_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one edge after a read |
| rsp_rdata | output | 32 | Read data |
| acc_err | output | 1 | One-cycle pulse for an illegal access |
| irq | output | 1 | Level interrupt |
| fifo_count | input | CNT_W | Data-queue fill count from the engine |
| rd_head | input | DATA_W | Head entry of the engine's data queue |
| rd_pop | output | 1 | Pop strobe to the engine |
| cmd_push | output | 1 | Command push strobe to the engine |
| cmd_data | output | 32 | Command word for the push |

## Verification
Two actions can fall in the same cycle: a software write that clears status bit 8, and the hardware setting that bit because the queue count is above threshold. The bench provokes this by holding the count above the threshold while it writes 0x100 to the status word. It expects the bit to survive, so the status reads 0x300. It then lowers the count below the threshold and repeats the write, which must clear the bit so the status reads 0x200.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        RI_CFG   = 3'd0,
        RI_ISTAT = 3'd1,
        RI_IMASK = 3'd2,
        RI_CSTAT = 3'd3,
        RI_CMD   = 3'd4,
        RI_RES   = 3'd5,
        RI_CTRL  = 3'd6
    } reg_idx_t;

    localparam logic [31:0] CFG_RST   = 32'h0000_1814;
    localparam logic [31:0] ISTAT_RST = 32'h0000_0200;
    localparam logic [31:0] IMASK_RST = 32'hFFFF_FFFF;
    localparam logic [31:0] CTRL_RST  = 32'h0000_0010;
    localparam logic [31:0] IMASK_KEEP = 32'h0000_03FF;
    localparam logic [31:0] CTRL_KEEP  = 32'h00FF_FEFF;

    localparam int BIT_CQ_LOW  = 9;
    localparam int BIT_DQ_HIGH = 8;
    localparam int BIT_CH_HOLD = 4;
    localparam int THR_LSB     = 16;
    localparam int THR_W       = 4;

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] istat;
        logic [31:0] imask;
        logic [31:0] ctrl;
        logic [31:0] rdata;
        logic        rvalid;
        logic        err;
        logic        push;
        logic [31:0] pdata;
        logic        pop;
        logic        irq;
    } host_state_t;

endpackage

// File: rtl/adc_host_decode.sv
module adc_host_decode
    import adc_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output reg_idx_t          sel,
    output logic              legal
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              mapped;

    always_comb begin
        word   = addr[ADDR_W-1:2];
        mapped = (addr[1:0] == 2'b00) && (word <= WORD_W'(6));
        sel    = reg_idx_t'(word[2:0]);
        legal  = 1'b0;
        if (mapped) begin
            case (sel)
                RI_CFG, RI_ISTAT, RI_IMASK, RI_CTRL: legal = 1'b1;
                RI_CSTAT, RI_RES:                    legal = !write;
                RI_CMD:                              legal = write;
                default:                             legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/adc_host_cstat.sv
module adc_host_cstat #(
    parameter int DEPTH = 15,
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] count,
    output logic [31:0]      word
);
    localparam int LVL_LSB = 12;

    always_comb begin
        word = 32'h0000_0400;
        word[LVL_LSB +: CNT_W] = count;
        if (count == '0)
            word[8] = 1'b1;
        else if (count == CNT_W'(DEPTH))
            word[9] = 1'b1;
    end
endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
    import adc_host_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 15,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              acc_err,
    output logic              irq,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [DATA_W-1:0] rd_head,
    output logic              rd_pop,
    output logic              cmd_push,
    output logic [31:0]       cmd_data
);
    host_state_t s_q, s_d;
    reg_idx_t    sel;
    logic        legal;
    logic [31:0] cstat_word;
    logic [31:0] istat_w, imask_w, ctrl_w;

    adc_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(req_addr), .write(req_write), .sel(sel), .legal(legal)
    );

    adc_host_cstat #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cst (
        .count(fifo_count), .word(cstat_word)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.err    = 1'b0;
        s_d.push   = 1'b0;
        s_d.pop    = 1'b0;
        if (req_valid) begin
            if (!legal) begin
                s_d.err = 1'b1;
                if (!req_write) begin
                    s_d.rvalid = 1'b1;
                    s_d.rdata  = '0;
                end
            end else if (req_write) begin
                case (sel)
                    RI_CFG:   s_d.cfg   = req_wdata;
                    RI_ISTAT: s_d.istat = s_q.istat & ~req_wdata;
                    RI_IMASK: s_d.imask = req_wdata & IMASK_KEEP;
                    RI_CTRL:  s_d.ctrl  = req_wdata & CTRL_KEEP;
                    RI_CMD: begin
                        if (!s_q.ctrl[BIT_CH_HOLD]) begin
                            s_d.push  = 1'b1;
                            s_d.pdata = req_wdata;
                        end
                    end
                    default: ;
                endcase
            end else begin
                s_d.rvalid = 1'b1;
                case (sel)
                    RI_CFG:   s_d.rdata = s_q.cfg;
                    RI_ISTAT: s_d.rdata = s_q.istat;
                    RI_IMASK: s_d.rdata = s_q.imask;
                    RI_CTRL:  s_d.rdata = s_q.ctrl;
                    RI_CSTAT: s_d.rdata = cstat_word;
                    RI_RES: begin
                        s_d.rdata = 32'(rd_head);
                        s_d.pop   = 1'b1;
                    end
                    default:  s_d.rdata = '0;
                endcase
            end
        end
        s_d.istat[BIT_CQ_LOW] = 1'b1;
        if (32'(fifo_count) > 32'(s_d.cfg[THR_LSB +: THR_W]))
            s_d.istat[BIT_DQ_HIGH] = 1'b1;
        s_d.irq = |(s_d.istat & ~s_d.imask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.cfg   <= CFG_RST;
            s_q.istat <= ISTAT_RST;
            s_q.imask <= IMASK_RST;
            s_q.ctrl  <= CTRL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rvalid;
    assign rsp_rdata = s_q.rdata;
    assign acc_err   = s_q.err;
    assign irq       = s_q.irq;
    assign rd_pop    = s_q.pop;
    assign cmd_push  = s_q.push;
    assign cmd_data  = s_q.pdata;
    assign istat_w   = s_q.istat;
    assign imask_w   = s_q.imask;
    assign ctrl_w    = s_q.ctrl;
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              acc_err,
    input logic              rd_pop,
    input logic              cmd_push,
    input logic [31:0]       istat,
    input logic [31:0]       imask,
    input logic [31:0]       ctrl
);
    logic clr8;
    assign clr8 = req_valid && req_write && (req_addr == ADDR_W'(4)) && req_wdata[8];

    a_r4_cq_low_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> istat[9]);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        istat[8] && !clr8 |=> istat[8]);

    a_r3_mask_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(imask) |-> imask[31:10] == 22'h0);

    a_r9_no_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[4] |=> !cmd_push);

    a_r10_pop_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> rsp_valid);

    a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err && rsp_valid |-> rsp_rdata == 32'h0);

    a_r11_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !cmd_push && !rd_pop);
endmodule

bind adc_host_regs adc_host_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .acc_err(acc_err), .rd_pop(rd_pop),
    .cmd_push(cmd_push), .istat(istat_w), .imask(imask_w), .ctrl(ctrl_w)
);

// File: tb/adc_host_regs_tb_top.sv
`timescale 1ns/1ps
module adc_host_regs_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 15;
    localparam int CNT_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, acc_err, irq, rd_pop, cmd_push;
    logic [31:0] rsp_rdata, cmd_data;
    logic [CNT_W-1:0] fifo_count = '0;
    logic [DATA_W-1:0] rd_head = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    adc_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .acc_err(acc_err), .irq(irq),
        .fifo_count(fifo_count), .rd_head(rd_head), .rd_pop(rd_pop),
        .cmd_push(cmd_push), .cmd_data(cmd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every read response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected response", rsp_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                            input bit exp_push, input bit exp_err, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(acc_err === exp_err, {tag, " err"}, 32'(acc_err), 32'(exp_err));
        chk(cmd_push === exp_push, {tag, " push"}, 32'(cmd_push), 32'(exp_push));
        if (exp_push) chk(cmd_data === d, {tag, " cmd_data"}, cmd_data, d);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] e,
                           input bit exp_pop, input bit exp_err, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(acc_err === exp_err, {tag, " err"}, 32'(acc_err), 32'(exp_err));
        chk(rd_pop === exp_pop, {tag, " pop"}, 32'(rd_pop), 32'(exp_pop));
    endtask

    task automatic set_count(input int c);
        @(negedge clk);
        fifo_count = CNT_W'(c);
        @(negedge clk);
    endtask

    task automatic chk_irq(input bit e, input string tag);
        @(negedge clk);
        chk(irq === e, tag, 32'(irq), 32'(e));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        do_read(8'h00, 32'h0000_1814, 0, 0, "R1 cfg reset");
        do_read(8'h04, 32'h0000_0200, 0, 0, "R1 istat reset");
        do_read(8'h08, 32'hFFFF_FFFF, 0, 0, "R1 imask reset");
        do_read(8'h18, 32'h0000_0010, 0, 0, "R1 ctrl reset");
        // R7 empty status
        do_read(8'h0C, 32'h0000_0500, 0, 0, "R7 cstat empty");
        // R2 config write, threshold 3
        do_write(8'h00, 32'h8003_2055, 0, 0, "R2 cfg write");
        do_read(8'h00, 32'h8003_2055, 0, 0, "R2 cfg readback");
        // R9 command held while ctrl bit4 set
        do_write(8'h10, 32'h0401_1234, 0, 0, "R9 cmd held");
        // R8 control masking
        do_write(8'h18, 32'hFFFF_FFFF, 0, 0, "R8 ctrl write");
        do_read(8'h18, 32'h00FF_FEFF, 0, 0, "R8 ctrl readback");
        do_write(8'h18, 32'h0000_0000, 0, 0, "R8 ctrl release");
        do_write(8'h10, 32'h0801_ABCD, 1, 0, "R9 cmd push");
        // R3 mask write, R6 irq
        do_write(8'h08, 32'hFFFF_FDFF, 0, 0, "R3 mask write");
        do_read(8'h08, 32'h0000_01FF, 0, 0, "R3 mask readback");
        chk_irq(1'b1, "R6 irq bit9 unmasked");
        // R4 bit 9 re-set
        do_write(8'h04, 32'hFFFF_FFFF, 0, 0, "R4 clear all");
        do_read(8'h04, 32'h0000_0200, 0, 0, "R4 bit9 stays");
        do_write(8'h08, 32'h0000_03FF, 0, 0, "R6 mask all");
        chk_irq(1'b0, "R6 irq masked");
        // R5 threshold
        set_count(3);
        do_read(8'h04, 32'h0000_0200, 0, 0, "R5 count equal thr");
        set_count(4);
        do_read(8'h04, 32'h0000_0300, 0, 0, "R5 count above thr");
        do_read(8'h0C, 32'h0000_4400, 0, 0, "R7 cstat level 4");
        set_count(2);
        do_read(8'h04, 32'h0000_0300, 0, 0, "R5 sticky");
        do_write(8'h04, 32'h0000_0100, 0, 0, "R5 clear below");
        do_read(8'h04, 32'h0000_0200, 0, 0, "R5 cleared");
        // R5 clear and set in the same cycle
        set_count(5);
        do_write(8'h04, 32'h0000_0100, 0, 0, "R5 clear vs set");
        do_read(8'h04, 32'h0000_0300, 0, 0, "R5 set wins");
        // R7 full
        set_count(15);
        do_read(8'h0C, 32'h0000_F600, 0, 0, "R7 cstat full");
        // R6 data-queue interrupt
        do_write(8'h08, 32'h0000_02FF, 0, 0, "R6 unmask bit8");
        chk_irq(1'b1, "R6 irq bit8");
        set_count(0);
        do_write(8'h04, 32'h0000_0100, 0, 0, "R6 clear bit8");
        chk_irq(1'b0, "R6 irq cleared");
        // R10 result pop
        rd_head = 16'hBEEF;
        do_read(8'h14, 32'h0000_BEEF, 1, 0, "R10 result read");
        // R11 illegal accesses
        do_read(8'h10, 32'h0, 0, 1, "R11 read cmd port");
        do_write(8'h0C, 32'hFFFF_FFFF, 0, 1, "R11 write cstat");
        do_write(8'h14, 32'hFFFF_FFFF, 0, 1, "R11 write result");
        do_read(8'h1C, 32'h0, 0, 1, "R11 unmapped read");
        do_write(8'h02, 32'h1234_5678, 0, 1, "R11 misaligned write");
        do_read(8'h00, 32'h8003_2055, 0, 0, "R11 cfg untouched");
        do_write(8'h20, 32'h0000_0000, 0, 1, "R11 unmapped write");
        do_read(8'h08, 32'h0000_02FF, 0, 0, "R11 mask untouched");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule